// File: doc/BRIEF.md
# Calibration Step Sequencer

The block runs a converter calibration as an ordered series of steps. Each step is carried out by a separate step engine outside the block. There are five such engines:

- an internal DAC calibration engine;
- an internal gain engine and an internal offset engine;
- a system gain engine and a system offset engine.

When a start pulse is seen while the block is idle, it captures a 3-bit calibration code. The code is made up of a mode bit and a 2-bit selector. The code picks one of eight fixed step lists. For each step in the list, the block gives the matching engine a one-cycle start strobe. It then waits, for as long as it takes, for that engine's done input.

After the final step's done has been taken, the block pulses a completion output for one cycle. Control logic uses this pulse to clear its start command bit. Busy is high from the first cycle after the start pulse is sampled up to and including the completion cycle. Nothing about the step arithmetic is handled here.

The controller has four states:

| State | Meaning |
|---|---|
| ST_IDLE | Waiting for a start pulse. |
| ST_LAUNCH | The strobe for the current step is driven for one cycle. |
| ST_WAIT | Watching the active engine's done input. |
| ST_FINISH | The completion pulse is driven. |

Its transitions are:

| From | To | Condition |
|---|---|---|
| ST_IDLE | ST_LAUNCH | A start pulse is sampled. The code is captured and the step index is cleared. |
| ST_LAUNCH | ST_WAIT | Always. |
| ST_WAIT | ST_LAUNCH | The active engine's done is sampled and steps remain. The step index advances. |
| ST_WAIT | ST_FINISH | The active engine's done is sampled and the step was the last. |
| ST_FINISH | ST_IDLE | Always. |

Top module: `cal_step_seq`

## Requirements
- R1: While reset is held and in the first cycle after reset is released, busy_o, cal_done_o and all bits of step_go_o are 0.
- R2: The code is {cal_mode_i, cal_sel_i[1:0]}. Engine strobe bits in step_go_o and step_done_i are: bit0 DAC, bit1 internal gain, bit2 internal offset, bit3 system gain, bit4 system offset. Code 000 strobes bit0, then bit1, then bit2.
- R3: Code 001 strobes bit1 then bit2. Code 010 strobes bit2 only. Code 011 strobes bit1 only.
- R4: Code 100 strobes bit0, then bit3, then bit4. Code 101 strobes bit3 then bit4. Code 110 strobes bit4 only. Code 111 strobes bit3 only.
- R5: Each strobe lasts exactly one cycle, and at most one strobe bit is high in any cycle. The first strobe of a run is in the first cycle in which busy_o is high, which is the cycle after start_i is sampled.
- R6: After a strobe the block waits with no cycle limit. During the wait it drives no strobe. It ignores done bits of all engines other than the active one, and it ignores the active engine's done in the strobe cycle itself.
- R7: Once the active engine's done is sampled, the next step's strobe comes in the following cycle. If that step was the last, cal_done_o is instead high for one cycle with busy_o still high, and busy_o is 0 in the cycle after that.
- R8: The code is captured only when the start pulse is accepted. Changes to cal_mode_i or cal_sel_i during a run do not change that run's step list.
- R9: start_i is ignored while busy_o is high, including the completion cycle. Such a request starts no run afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Calibration start request |
| cal_mode_i | input | 1 | Code bit 2: 0 internal, 1 system |
| cal_sel_i | input | 2 | Code bits 1:0, step selector |
| step_done_i | input | 5 | Done handshake from each engine (bit map in R2) |
| step_go_o | output | 5 | One-cycle start strobe to each engine (bit map in R2) |
| busy_o | output | 1 | A calibration run is in progress |
| cal_done_o | output | 1 | One-cycle completion pulse, used to clear the start bit |

## Verification
Two pairs of events can fall in the same cycle:

- **A start request and the completion pulse.** The bench waits until it sees cal_done_o, then raises start_i for exactly that cycle. It expects busy_o to fall and stay low, with no new strobe.
- **An engine's done and its own strobe.** A responder option drives done in the strobe cycle itself. The bench expects that early pulse to be ignored, and the step to end only on the later pulse.

Both cases are judged by a per-cycle behavioural model that keeps the pending steps in a queue. The model is compared against busy_o, step_go_o and cal_done_o on every clock.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    localparam int NUM_ENG   = 5;
    localparam int ENG_W     = $clog2(NUM_ENG);
    localparam int MAX_STEPS = 3;
    localparam int IDX_W     = $clog2(MAX_STEPS);
    localparam int SEL_W     = 2;

    // Engine numbering: fixes the bit order of strobe and done vectors
    typedef enum logic [ENG_W-1:0] {
        ENG_DAC   = 3'd0,
        ENG_IGAIN = 3'd1,
        ENG_IOFF  = 3'd2,
        ENG_SGAIN = 3'd3,
        ENG_SOFF  = 3'd4
    } eng_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_FINISH
    } state_e;

    typedef struct packed {
        logic             sys;
        logic [SEL_W-1:0] sel;
    } cal_code_t;

endpackage

// File: rtl/cal_seq_plan.sv
// Maps a captured calibration code and a step index to the engine of that
// step, and flags whether it is the final step of the list.
module cal_seq_plan
    import cal_seq_pkg::*;
(
    input  cal_code_t        code,
    input  logic [IDX_W-1:0] idx,
    output logic [ENG_W-1:0] eng,
    output logic             last
);

    logic [ENG_W-1:0] gain_eng;
    logic [ENG_W-1:0] offs_eng;

    // Mode bit chooses between the internal and system gain/offset engines
    always_comb begin
        gain_eng = code.sys ? ENG_SGAIN : ENG_IGAIN;
        offs_eng = code.sys ? ENG_SOFF  : ENG_IOFF;
    end

    always_comb begin
        eng  = offs_eng;
        last = 1'b1;
        unique case (code.sel)
            2'b00: begin
                // Full list: DAC, then gain, then offset
                if (idx == IDX_W'(0)) begin
                    eng  = ENG_DAC;
                    last = 1'b0;
                end else if (idx == IDX_W'(1)) begin
                    eng  = gain_eng;
                    last = 1'b0;
                end else begin
                    eng  = offs_eng;
                    last = 1'b1;
                end
            end
            2'b01: begin
                // Gain, then offset
                if (idx == IDX_W'(0)) begin
                    eng  = gain_eng;
                    last = 1'b0;
                end else begin
                    eng  = offs_eng;
                    last = 1'b1;
                end
            end
            2'b10: begin
                eng  = offs_eng;
                last = 1'b1;
            end
            2'b11: begin
                eng  = gain_eng;
                last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cal_seq_go.sv
// Turns the active engine number into a strobe vector and picks out that
// engine's done input from the handshake vector.
module cal_seq_go
    import cal_seq_pkg::*;
(
    input  logic [ENG_W-1:0]   eng,
    input  logic               fire,
    input  logic [NUM_ENG-1:0] done_vec,
    output logic [NUM_ENG-1:0] go_vec,
    output logic               done_hit
);

    logic [NUM_ENG-1:0] sel_mask;

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        assign sel_mask[e] = (eng == ENG_W'(e));
        assign go_vec[e]   = fire & sel_mask[e];
    end

    assign done_hit = |(done_vec & sel_mask);

endmodule

// File: rtl/cal_step_seq.sv
module cal_step_seq
    import cal_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               cal_mode_i,
    input  logic [SEL_W-1:0]   cal_sel_i,
    input  logic [NUM_ENG-1:0] step_done_i,
    output logic [NUM_ENG-1:0] step_go_o,
    output logic               busy_o,
    output logic               cal_done_o
);

    state_e           state_q;
    state_e           state_d;
    cal_code_t        code_q;
    cal_code_t        code_in;
    logic [IDX_W-1:0] idx_q;
    logic [ENG_W-1:0] cur_eng;
    logic             cur_last;
    logic             fire;
    logic             done_hit;
    logic             accept;
    logic             advance;

    assign code_in.sys = cal_mode_i;
    assign code_in.sel = cal_sel_i;

    cal_seq_plan u_plan (
        .code (code_q),
        .idx  (idx_q),
        .eng  (cur_eng),
        .last (cur_last)
    );

    cal_seq_go u_go (
        .eng      (cur_eng),
        .fire     (fire),
        .done_vec (step_done_i),
        .go_vec   (step_go_o),
        .done_hit (done_hit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept  = 1'b1;
                    state_d = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (done_hit) begin
                    if (cur_last) begin
                        state_d = ST_FINISH;
                    end else begin
                        advance = 1'b1;
                        state_d = ST_LAUNCH;
                    end
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Captured code and step index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            idx_q  <= '0;
        end else if (accept) begin
            code_q <= code_in;
            idx_q  <= '0;
        end else if (advance) begin
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    // Output decode
    always_comb begin
        fire       = 1'b0;
        busy_o     = 1'b1;
        cal_done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o     = 1'b0;
            ST_LAUNCH: fire       = 1'b1;
            ST_WAIT:   fire       = 1'b0;
            ST_FINISH: cal_done_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/cal_step_seq_chk.sv
module cal_step_seq_chk
    import cal_seq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [NUM_ENG-1:0] step_go_o,
    input logic               busy_o,
    input logic               cal_done_o,
    input cal_code_t          code_q
);

    // R5: never two engines strobed together
    a_r5_go_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_go_o));

    // R5: a strobe lasts one cycle
    a_r5_go_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|step_go_o) |=> (step_go_o == '0));

    // R5: strobes only inside a run
    a_r5_go_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (|step_go_o) |-> busy_o);

    // R5: first busy cycle carries the first strobe
    a_r5_first_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (|step_go_o));

    // R7: completion is a single cycle inside busy, then idle
    a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done_o |-> busy_o);

    a_r7_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done_o |=> (!cal_done_o && !busy_o));

    // R8: captured code held for the whole run
    a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(code_q));

    // R9: a start in the completion cycle does not restart
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done_o && start_i) |=> !busy_o);

endmodule

bind cal_step_seq cal_step_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .step_go_o  (step_go_o),
    .busy_o     (busy_o),
    .cal_done_o (cal_done_o),
    .code_q     (code_q)
);

// File: tb/cal_step_seq_bench.sv
module cal_step_seq_bench;
    import cal_seq_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n;
    logic               start;
    logic               mode;
    logic [1:0]         sel;
    logic [NUM_ENG-1:0] done;
    logic [NUM_ENG-1:0] resp;
    logic [NUM_ENG-1:0] stray;
    logic [NUM_ENG-1:0] go;
    logic               busy;
    logic               cdone;

    assign done = resp | stray;

    cal_step_seq u_cal_step_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cal_mode_i  (mode),
        .cal_sel_i   (sel),
        .step_done_i (done),
        .step_go_o   (go),
        .busy_o      (busy),
        .cal_done_o  (cdone)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 strobe, 2 wait, 3 complete
    int m_phase = 0;
    int m_q[$];
    int m_list[$];
    int m_code = 0;
    bit m_changed = 0;
    int log_q[$];

    function automatic void load_plan(input int code);
        int g;
        int o;
        g = code[2] ? 3 : 1;
        o = code[2] ? 4 : 2;
        m_q.delete();
        case (code & 3)
            0: begin m_q.push_back(0); m_q.push_back(g); m_q.push_back(o); end
            1: begin m_q.push_back(g); m_q.push_back(o); end
            2: m_q.push_back(o);
            default: m_q.push_back(g);
        endcase
        m_list = m_q;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            m_q.delete();
        end else begin
            case (m_phase)
                0: if (start) begin
                    m_code = {29'd0, mode, sel};
                    load_plan(m_code);
                    m_phase = 1;
                end
                1: m_phase = 2;
                2: if (done[m_q[0]]) begin
                    void'(m_q.pop_front());
                    m_phase = (m_q.size() == 0) ? 3 : 1;
                end
                default: m_phase = 0;
            endcase
        end
    end

    function automatic int onehot_idx(input logic [NUM_ENG-1:0] v);
        for (int i = 0; i < NUM_ENG; i++) if (v[i]) return i;
        return -1;
    endfunction

    // Per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NUM_ENG-1:0] exp_go;
            string tag;
            exp_go = (m_phase == 1) ? NUM_ENG'(1 << m_q[0]) : '0;
            chk(busy == (m_phase != 0), "R9 R7 busy", busy, m_phase != 0);
            chk(go == exp_go, "R5 R6 strobe", go, exp_go);
            chk(cdone == (m_phase == 3), "R7 complete", cdone, m_phase == 3);
            if (go != '0) log_q.push_back(onehot_idx(go));
            if (cdone) begin
                if (m_changed) tag = "R8 order";
                else if (m_code[2]) tag = "R4 order";
                else if (m_code == 0) tag = "R2 order";
                else tag = "R3 order";
                chk(log_q.size() == m_list.size(), tag, log_q.size(), m_list.size());
                for (int i = 0; i < m_list.size() && i < log_q.size(); i++)
                    chk(log_q[i] == m_list[i], tag, log_q[i], m_list[i]);
                log_q.delete();
            end
        end
    end

    // Engine responder
    int  lat_cfg = 0;
    bit  early = 0;
    int  r_cnt = 0;
    int  r_eng = 0;
    bit  r_pend = 0;
    always @(negedge clk) begin
        #1;
        resp = '0;
        if (go != '0) begin
            r_eng  = onehot_idx(go);
            r_cnt  = lat_cfg;
            r_pend = 1;
            if (early) resp[r_eng] = 1'b1;
        end else if (r_pend) begin
            if (r_cnt == 0) begin
                resp[r_eng] = 1'b1;
                r_pend = 0;
            end else begin
                r_cnt--;
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic pulse_start(input int code);
        @(negedge clk); #1;
        mode = code[2];
        sel = code[1:0];
        start = 1'b1;
        m_changed = 0;
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        @(negedge clk);
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        mode = 1'b0;
        sel = 2'b00;
        stray = '0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && go == 0 && cdone == 0, "R1 in reset", {busy, cdone, go}, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && go == 0 && cdone == 0, "R1 after reset", {busy, cdone, go}, 0);

        // All eight codes, varied latencies (R2 R3 R4)
        for (int c = 0; c < 8; c++) begin
            lat_cfg = c % 3;
            pulse_start(c);
            wait_idle();
        end

        // Long wait with done on foreign engines (R6)
        lat_cfg = 40;
        pulse_start(6);
        repeat (10) begin
            @(negedge clk); #1;
            stray = 5'b01111;
        end
        @(negedge clk);
        chk(busy == 1 && go == 0, "R6 waiting", {busy, go}, 6'b100000);
        #1 stray = '0;
        wait_idle();

        // Done together with its own strobe is ignored (R6)
        lat_cfg = 3;
        early = 1;
        pulse_start(1);
        wait_idle();
        pulse_start(4);
        wait_idle();
        early = 0;

        // Code changes mid-run (R8)
        lat_cfg = 4;
        pulse_start(0);
        repeat (2) @(negedge clk);
        #1;
        mode = 1'b1;
        sel = 2'b11;
        m_changed = 1;
        wait_idle();

        // Starts during busy and in the completion cycle (R9)
        lat_cfg = 2;
        pulse_start(5);
        repeat (3) begin
            @(negedge clk); #1 start = 1'b1;
            @(negedge clk); #1 start = 1'b0;
        end
        while (!cdone) @(negedge clk);
        #1 start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(busy == 0 && go == 0, "R9 no restart", {busy, go}, 0);
        end

        finish_run();
    end

endmodule